// File: doc/BRIEF.md
# Packed Multimedia SIMD ALU

This block is a registered packed-arithmetic datapath. It treats each of its two operand words as a row of independent lanes. A 4-bit opcode chooses both the operation and the lane width. There is no separate length setting: the low two opcode bits of the add and compare families pick bytes, 16-bit words, 32-bit doublewords or one 64-bit quadword.

The operations are:
- Lane-wise wrapping add, with carries cut at every lane edge.
- Lane-wise equality compare that yields all-ones or all-zeros lane masks.
- The bitwise AND, inverted-AND and OR steps used to merge two pixel streams under a mask without branching.
- A signed 16-bit multiply with pairwise summing, which is the kernel of dot products. Its 32-bit pair sums are accumulated with the doubleword add.

A caller presents both operands and an opcode with `valid_in` high. One clock later `result` carries the answer and `valid_out` is high. When no valid operands arrive, the result register keeps its last value.

Top module: `simd_pack_alu`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `valid_out` is 0 and `result` is 0.
- R2: Opcodes 0000, 0001, 0010 and 0011 add `a` and `b` lane by lane, with lane widths of 8, 16, 32 and 64 bits respectively. Each lane sum wraps modulo 2^width.
- R3: No carry ever crosses a lane boundary. An overflowing lane affects no other lane, and no overflow flag exists.
- R4: Opcodes 0100, 0101, 0110 and 0111 compare `a` and `b` per lane, with lane widths of 8, 16, 32 and 64 bits. Each result lane is all ones when the two elements are equal and all zeros otherwise, even if only one byte of the lane differs.
- R5: Opcode 1000 gives `a & b`, opcode 1001 gives `~a & b`, and opcode 1010 gives `a | b`. With a compare mask as `a`, these three combine two pixel operands into a per-byte selection.
- R6: Opcode 1011 forms four signed 16x16 products of the 16-bit lanes, where lane k sits at bits 16k+15:16k. Products 0 and 1 are summed into bits 31:0 and products 2 and 3 into bits 63:32.
- R7: The multiply-add pair sums wrap modulo 2^32. Two products of -32768 x -32768 give 0x80000000.
- R8: Opcodes 1100 to 1111 produce a result of 0.
- R9: `valid_out` equals `valid_in` from one clock earlier, and the result of a transfer appears exactly one cycle after it.
- R10: When `valid_in` is low, `result` keeps its previous value whatever `op`, `a` and `b` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_in | input | 1 | Operands and opcode are valid this cycle |
| op | input | 4 | Operation and lane-width select |
| a | input | DW | First packed operand (mask operand for selection) |
| b | input | DW | Second packed operand |
| valid_out | output | 1 | `result` holds a new answer |
| result | output | DW | Registered packed result |

## Verification
The bench builds the block with its default width DW = 64. At that width the block has eight byte lanes, four 16-bit lanes, two pair sums and one quadword lane, so each lane format has both an interior boundary and the full-width case within reach. The bench's own per-lane model predicts carries that must stop at each boundary, compares that differ in only one byte of a wide lane, and the most-negative multiply-add pair wrap. Back-to-back transfers and idle cycles with junk operands exercise the one-cycle latency and the hold behaviour.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [1:0] {
    FAM_ADD = 2'b00,
    FAM_CEQ = 2'b01,
    FAM_LOG = 2'b10,
    FAM_RSV = 2'b11
  } fam_e;

  typedef enum logic [1:0] {
    LN_BYTE  = 2'b00,
    LN_WORD  = 2'b01,
    LN_DWORD = 2'b10,
    LN_QWORD = 2'b11
  } lane_e;

  localparam logic [1:0] SUB_AND  = 2'b00;
  localparam logic [1:0] SUB_ANDN = 2'b01;
  localparam logic [1:0] SUB_OR   = 2'b10;
  localparam logic [1:0] SUB_MADD = 2'b11;

  // number of bytes in one lane of the given format
  function automatic int unsigned lane_bytes(lane_e s);
    return 32'd1 << s;
  endfunction

  // true when byte idx is the lowest byte of its lane
  function automatic logic lane_start(int unsigned idx, lane_e s);
    return (idx & (lane_bytes(s) - 32'd1)) == 32'd0;
  endfunction

  // 8-bit add with carry in, carry out in bit 8
  function automatic logic [8:0] byte_add(logic [7:0] x, logic [7:0] y, logic ci);
    return {1'b0, x} + {1'b0, y} + {8'b0, ci};
  endfunction

  // signed 16x16 product, full 32 bits
  function automatic logic [31:0] mul16s(logic [15:0] x, logic [15:0] y);
    logic signed [31:0] xs;
    logic signed [31:0] ys;
    xs = $signed({{16{x[15]}}, x});
    ys = $signed({{16{y[15]}}, y});
    return 32'(xs * ys);
  endfunction

endpackage

// File: rtl/simd_lane_add.sv
module simd_lane_add
  import simd_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  lane_e         sz,
  output logic [DW-1:0] sum
);
  localparam int NB = DW / 8;

  logic [NB-1:0] carry_cut;
  logic [NB:0]   carry;

  always_comb begin
    carry[0] = 1'b0;
    sum      = '0;
    for (int i = 0; i < NB; i++) begin
      logic [8:0] t;
      carry_cut[i] = lane_start(i, sz);
      t = byte_add(a[8*i +: 8], b[8*i +: 8], carry_cut[i] ? 1'b0 : carry[i]);
      sum[8*i +: 8] = t[7:0];
      carry[i+1]    = t[8];
    end
  end
endmodule

// File: rtl/simd_lane_cmp.sv
module simd_lane_cmp
  import simd_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  lane_e         sz,
  output logic [DW-1:0] mask
);
  localparam int NB = DW / 8;

  logic [NB-1:0] byte_eq;
  logic [NB-1:0] lane_eq;

  for (genvar g = 0; g < NB; g++) begin : g_eq
    assign byte_eq[g] = (a[8*g +: 8] == b[8*g +: 8]);
  end

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      lane_eq[i] = 1'b1;
      for (int j = 0; j < NB; j++) begin
        if ((j >> sz) == (i >> sz)) lane_eq[i] = lane_eq[i] & byte_eq[j];
      end
      mask[8*i +: 8] = {8{lane_eq[i]}};
    end
  end
endmodule

// File: rtl/simd_madd.sv
module simd_madd
  import simd_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] pair_sum
);
  localparam int NH = DW / 16;
  localparam int NP = DW / 32;

  logic [31:0] prod [NH];

  for (genvar k = 0; k < NH; k++) begin : g_mul
    assign prod[k] = mul16s(a[16*k +: 16], b[16*k +: 16]);
  end

  for (genvar p = 0; p < NP; p++) begin : g_pair
    assign pair_sum[32*p +: 32] = prod[2*p] + prod[2*p+1];
  end
endmodule

// File: rtl/simd_pack_alu.sv
module simd_pack_alu
  import simd_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_in,
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic          valid_out,
  output logic [DW-1:0] result
);
  localparam int NB = DW / 8;

  fam_e          fam;
  lane_e         sz;
  logic [DW-1:0] add_sum;
  logic [DW-1:0] cmp_mask;
  logic [DW-1:0] madd_sum;
  logic [DW-1:0] nxt;
  logic          valid_q;
  logic [DW-1:0] res_q;

  assign fam = fam_e'(op[3:2]);
  assign sz  = lane_e'(op[1:0]);

  simd_lane_add #(.DW(DW)) u_add (.a(a), .b(b), .sz(sz), .sum(add_sum));
  simd_lane_cmp #(.DW(DW)) u_cmp (.a(a), .b(b), .sz(sz), .mask(cmp_mask));
  simd_madd     #(.DW(DW)) u_mad (.a(a), .b(b), .pair_sum(madd_sum));

  always_comb begin
    unique case (fam)
      FAM_ADD: nxt = add_sum;
      FAM_CEQ: nxt = cmp_mask;
      FAM_LOG: begin
        unique case (op[1:0])
          SUB_AND:  nxt = a & b;
          SUB_ANDN: nxt = ~a & b;
          SUB_OR:   nxt = a | b;
          default:  nxt = madd_sum;
        endcase
      end
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= valid_in;
      if (valid_in) res_q <= nxt;
    end
  end

  assign valid_out = valid_q;
  assign result    = res_q;

  // every byte is 00 or FF
  function automatic logic bytes_uniform(logic [DW-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NB; i++)
      ok = ok & ((v[8*i +: 8] == 8'h00) || (v[8*i +: 8] == 8'hFF));
    return ok;
  endfunction

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!valid_out && result == '0));

  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (valid_out == $past(valid_in)));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(valid_in)) |-> $stable(result));

  a_r3_byte1_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(valid_in) && $past(op) == 4'b0000)
      |-> (result[15:8] == 8'($past(a[15:8]) + $past(b[15:8]))));

  a_r4_mask_form: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(valid_in) && $past(op[3:2]) == 2'b01)
      |-> bytes_uniform(result));

  a_r6_madd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(valid_in) && $past(op) == 4'b1011 && $past(b) == '0)
      |-> (result == '0));

  a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(valid_in) && $past(op[3:2]) == 2'b11)
      |-> (result == '0));
endmodule

// File: tb/simd_pack_alu_test.sv
module simd_pack_alu_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [3:0]  op = 4'h0;
  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic        valid_out;
  logic [63:0] result;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [63:0] exp_q [$];
  string       tag_q [$];
  logic [63:0] last_exp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_pack_alu #(.DW(64)) uut (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op(op), .a(a), .b(b),
    .valid_out(valid_out), .result(result)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] lmask(int w);
    return (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
  endfunction

  // independent reference model, lane by lane
  function automatic logic [63:0] model(logic [3:0] o, logic [63:0] x, logic [63:0] y);
    logic [63:0] r = '0;
    int w = 8 << o[1:0];
    logic [63:0] m = lmask(w);
    case (o[3:2])
      2'b00: for (int k = 0; k < 64 / w; k++)
               r |= (((x >> (k*w)) & m) + ((y >> (k*w)) & m) & m) << (k*w);
      2'b01: for (int k = 0; k < 64 / w; k++)
               if (((x >> (k*w)) & m) == ((y >> (k*w)) & m)) r |= m << (k*w);
      2'b10: case (o[1:0])
               2'b00: r = x & y;
               2'b01: r = (x ^ 64'hFFFF_FFFF_FFFF_FFFF) & y;
               2'b10: r = x | y;
               default: for (int p = 0; p < 2; p++) begin
                 int s0, s1, t0, t1, acc;
                 s0 = int'($signed(x[32*p +: 16]));
                 t0 = int'($signed(y[32*p +: 16]));
                 s1 = int'($signed(x[32*p+16 +: 16]));
                 t1 = int'($signed(y[32*p+16 +: 16]));
                 acc = s0 * t0 + s1 * t1;
                 r[32*p +: 32] = acc;
               end
             endcase
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic send(logic [3:0] o, logic [63:0] x, logic [63:0] y, string tag);
    @(negedge clk);
    op = o; a = x; b = y; valid_in = 1'b1;
    exp_q.push_back(model(o, x, y));
    tag_q.push_back(tag);
  endtask

  task automatic idle_junk(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_in = 1'b0;
      op = 4'(i * 5 + 3);
      a = {16{4'(i + 7)}};
      b = ~a;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && valid_out) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R9 actual=unexpected valid_out expected=none");
      end else begin
        string t;
        logic [63:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        last_exp = e;
        check(t, result, e);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {63'd0, valid_out}, 64'd0);
    check("R1 reset result", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 first cycle valid", {63'd0, valid_out}, 64'd0);

    // R2 / R3 adds
    send(4'b0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, "R3 byte wrap");
    send(4'b0000, 64'h1080_7F01_FE22_3344, 64'h2080_0102_0311_0C0C, "R2 byte add");
    send(4'b0001, 64'h00FF_FFFF_00FF_8000, 64'h0001_0001_0001_8000, "R3 word add");
    send(4'b0010, 64'h0000_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, "R3 dword add");
    send(4'b0011, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, "R2 qword add");
    send(4'b0011, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0002, "R2 qword wrap");
    // R4 compares
    send(4'b0100, 64'h1122_3344_5566_7788, 64'h1122_0044_5500_7788, "R4 byte cmp");
    send(4'b0101, 64'h1122_3344_5566_7788, 64'h1122_3344_5566_7789, "R4 word cmp");
    send(4'b0110, 64'hAAAA_BBBB_CCCC_DDDD, 64'hAAAA_BBBB_CCCC_DDDC, "R4 dword cmp");
    send(4'b0111, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, "R4 qword eq");
    send(4'b0111, 64'h0123_4567_89AB_CDEF, 64'h8123_4567_89AB_CDEF, "R4 qword ne");
    // R5 select steps: mask FF00FF00..., x and y pixels
    send(4'b1000, 64'hFF00_FF00_FF00_FF00, 64'h1122_3344_5566_7788, "R5 and");
    send(4'b1001, 64'hFF00_FF00_FF00_FF00, 64'h99AA_BBCC_DDEE_F011, "R5 andn");
    send(4'b1010, 64'h1100_3300_5500_7700, 64'h00AA_00CC_00EE_0011, "R5 or");
    // R6 / R7 multiply-add: lanes {7,100,-2,3} x {-9,-1,4,5}
    send(4'b1011, 64'h0007_0064_FFFE_0003, 64'hFFF7_FFFF_0004_0005, "R6 madd");
    send(4'b1011, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0000_0000, "R6 madd zero");
    send(4'b1011, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, "R7 madd wrap");
    send(4'b1011, 64'h7FFF_7FFF_0001_FFFF, 64'h7FFF_7FFF_FFFF_FFFF, "R7 madd mix");
    // R8 unused opcodes
    for (int u = 12; u < 16; u++)
      send(4'(u), 64'hDEAD_BEEF_0BAD_F00D, 64'h1357_9BDF_2468_ACE0, "R8 unused");
    send(4'b0010, 64'h0000_0005_0000_0007, 64'h0000_0001_0000_0002, "R9 last");
    // R10 hold with junk inputs
    idle_junk(1);
    idle_junk(4);
    check("R9 idle valid", {63'd0, valid_out}, 64'd0);
    check("R10 hold", result, last_exp);
    check("R10 hold value", result, 64'h0000_0006_0000_0009);
    idle_junk(2);
    check("R9 queue drained", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule